// File: doc/BRIEF.md
# Variable-Length Code Byte Decoder

This block takes code bytes one at a time from a memory read port and builds one whole instruction from them. An instruction can start with any number of prefix bytes. These prefixes can extend the condition code, toggle whether the flags are written, turn on address translation for one instruction, or redirect the destination register. After the prefixes comes an opcode byte. Depending on the opcode, a register-pair byte may follow, and then one or two immediate bytes. When the last byte of an instruction has been taken, the block pulses `done` and presents the decoded fields on registered outputs. Those outputs hold until the next instruction completes.

The block also keeps the fetch address. Every accepted code byte advances it by one plus the delta-PC value supplied on `dpc`, so code can be laid out with a stride. A redirect input reloads the address and throws away any instruction that is only partly assembled. The fetch unit drives `byte_valid` whenever a byte read at `fetch_pc` returns. The execute stage takes the decoded fields on `done`.

Top module: `code_byte_decoder`

## Requirements
- R1: Every non-prefix code byte carries a 3-bit condition in bits 7:5 and a 5-bit opcode in bits 4:0. Without the extend prefix, `cond` is `{1'b0, bits 7:5}` and `opcode` is bits 4:0.
- R2: A byte whose bits 7:5 equal 6 is a prefix. 0xC0 adds 8 to the condition of the instruction (sets `cond[3]`). 0xC1 toggles `pfx_tf`, so two of them cancel. 0xC2 sets `pfx_em`.
- R3: A byte from 0xD0 to 0xDF sets `rd` to its low nybble and raises `pfx_dr`. If several appear, the last one wins. With no such prefix, `rd` equals `rx`. `rdx` is always `rd` with bit 0 inverted.
- R4: The following complete an instruction with `illegal`=1 on the byte that causes it: a reserved prefix 0xC3–0xCF, a reserved opcode 0x0E or 0x0F, or any prefix that follows the 0xC0 prefix.
- R5: Opcodes 0x00–0x0D and 0x10–0x14, 0x16, 0x18, 0x19 and 0x1C take a register-pair byte next. Its bits 7:4 give `rx` and bits 3:0 give `ry`.
- R6: For word-operand opcodes (0x00–0x0D, 0x10–0x12, 0x14, 0x16), an `ry` of 15 makes two immediate bytes follow, low byte first. The result is `has_imm`=1 and `imm` = {second byte, first byte}.
- R7: For byte-operand opcodes 0x13 and 0x19, an `ry` of 15 makes one immediate byte follow. It is zero-extended into `imm`. With any other `ry`, these opcodes and also 0x18 and 0x1C end at the pair byte with `has_imm`=0.
- R8: Opcodes 0x15, 0x17, 0x1A and 0x1B take a bare 16-bit immediate, low byte first. They have no pair byte, and they report `rx`=`ry`=0.
- R9: Opcodes 0x1D, 0x1E and 0x1F complete on the opcode byte itself.
- R10: `simm4` is the 16-bit value of `ry` read as a 4-bit signed number, plus 1 when that number is 0 or more. For example, 0→1, 7→8, 8→−8 and 15→−1. It is never zero.
- R11: Each accepted byte moves `fetch_pc` to `fetch_pc + 1 + dpc` (modulo 2^16). A redirect loads `redirect_pc`. With neither, `fetch_pc` holds. After reset it is 0.
- R12: A redirect in the same cycle as a valid byte wins. The byte is dropped, `fetch_pc` takes `redirect_pc`, no `done` follows, and decoding restarts from an empty prefix state.
- R13: `upd_flags` is 1 exactly when the final condition is 7 (always) XOR `pfx_tf` is 1.
- R14: `done` is high for exactly the one cycle after the final byte is accepted. All decoded outputs stay unchanged between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect | input | 1 | Load a new fetch address and abandon the partial instruction |
| redirect_pc | input | 16 | Address loaded on redirect |
| dpc | input | 16 | Delta-PC value added to each fetch step |
| byte_valid | input | 1 | A code byte is present on byte_data |
| byte_data | input | 8 | Code byte read at fetch_pc |
| fetch_pc | output | 16 | Address of the next code byte to read |
| done | output | 1 | One-cycle pulse: decoded fields are new |
| illegal | output | 1 | Completed instruction was illegal |
| cond | output | 4 | Final condition code |
| opcode | output | 5 | Opcode |
| rx | output | 4 | First operand register |
| ry | output | 4 | Second operand register field |
| rd | output | 4 | Destination register |
| rdx | output | 4 | Paired destination register (rd XOR 1) |
| has_imm | output | 1 | An immediate was fetched |
| imm | output | 16 | Immediate value |
| simm4 | output | 16 | Small signed immediate decoded from ry |
| pfx_tf | output | 1 | Flags-toggle prefix state |
| pfx_em | output | 1 | Translation-enable prefix seen |
| pfx_dr | output | 1 | Destination prefix seen |
| upd_flags | output | 1 | Instruction writes the flags |

## Verification
The byte-accept path and the redirect path can both act in the same cycle. Both of them update the fetch address and the assembly state. The bench provokes this by raising `redirect` together with a valid pair byte while an instruction is half built. It then judges that `fetch_pc` equals the redirect target, not the stepped value, and that no completion pulse appears. A following single-byte opcode must decode as a fresh instruction, not as the dropped pair byte. A second overlap is a completion pulse in the same cycle as the first byte of the next instruction. Back-to-back single-byte opcodes provoke this, and the bench checks both completions.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int RIDX_W = 4;
  localparam int OP_W   = 5;
  localparam int CND_W  = 3;

  localparam logic [CND_W-1:0]  COND_PREFIX = 3'd6;
  localparam logic [CND_W:0]    COND_ALWAYS = 4'd7;
  localparam logic [RIDX_W-1:0] RIDX_IMM    = 4'hF;

  typedef enum logic [1:0] {
    ST_HEAD, ST_PAIR, ST_LO, ST_HI
  } cbd_state_e;

  typedef enum logic [2:0] {
    K_RSVD, K_SINGLE, K_BARE16, K_PAIR_VY, K_PAIR_V8, K_PAIR_NOIMM
  } cbd_kind_e;
endpackage

// File: rtl/cbd_op_class.sv
module cbd_op_class
  import cbd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output cbd_kind_e       kind
);
  always_comb begin
    if (op <= 5'h0D) begin
      kind = K_PAIR_VY;
    end else begin
      case (op)
        5'h0E, 5'h0F:                kind = K_RSVD;
        5'h10, 5'h11, 5'h12,
        5'h14, 5'h16:                kind = K_PAIR_VY;
        5'h13, 5'h19:                kind = K_PAIR_V8;
        5'h18, 5'h1C:                kind = K_PAIR_NOIMM;
        5'h15, 5'h17, 5'h1A, 5'h1B:  kind = K_BARE16;
        default:                     kind = K_SINGLE;
      endcase
    end
  end
endmodule

// File: rtl/cbd_simm4.sv
module cbd_simm4
  import cbd_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic [RIDX_W-1:0] code,
  output logic [OUT_W-1:0]  value
);
  logic [OUT_W-1:0] sext;
  assign sext  = {{(OUT_W-RIDX_W){code[RIDX_W-1]}}, code};
  assign value = code[RIDX_W-1] ? sext : sext + OUT_W'(1);
endmodule

// File: rtl/cbd_fetch_pc.sv
module cbd_fetch_pc #(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              step,
  input  logic [ADDR_W-1:0] dpc,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)           pc <= RESET_PC;
    else if (redirect) pc <= redirect_pc;
    else if (step)     pc <= pc + ADDR_W'(1) + dpc;
  end

  a_r11_step: assert property (@(posedge clk) disable iff (rst)
    (step && !redirect) |=> pc == $past(pc) + ADDR_W'(1) + $past(dpc));
  a_r12_redirect_wins: assert property (@(posedge clk) disable iff (rst)
    redirect |=> pc == $past(redirect_pc));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !redirect) |=> $stable(pc));
endmodule

// File: rtl/code_byte_decoder.sv
module code_byte_decoder
  import cbd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirect_pc,
  input  logic [ADDR_W-1:0]   dpc,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  output logic [ADDR_W-1:0]   fetch_pc,
  output logic                done,
  output logic                illegal,
  output logic [CND_W:0]      cond,
  output logic [OP_W-1:0]     opcode,
  output logic [RIDX_W-1:0]   rx,
  output logic [RIDX_W-1:0]   ry,
  output logic [RIDX_W-1:0]   rd,
  output logic [RIDX_W-1:0]   rdx,
  output logic                has_imm,
  output logic [WORD_W-1:0]   imm,
  output logic [WORD_W-1:0]   simm4,
  output logic                pfx_tf,
  output logic                pfx_em,
  output logic                pfx_dr,
  output logic                upd_flags
);
  // working state of the instruction under assembly
  cbd_state_e          state_q, state_d;
  cbd_kind_e           kind_q, kind_d, hd_kind;
  logic                xc_q, xc_d, tf_q, tf_d, em_q, em_d, drv_q, drv_d;
  logic [RIDX_W-1:0]   dr_q, dr_d, rx_q, rx_d, ry_q, ry_d;
  logic [OP_W-1:0]     op_q, op_d;
  logic [CND_W-1:0]    cnd_q, cnd_d;
  logic [BYTE_W-1:0]   lo_q, lo_d;

  // completion values
  logic                fin, fin_ill, fin_immv;
  logic [WORD_W-1:0]   fin_imm;
  logic [RIDX_W-1:0]   fin_rx, fin_ry;
  logic [OP_W-1:0]     fin_op;
  logic [CND_W-1:0]    fin_cnd;
  logic [CND_W:0]      fin_cond4;

  logic accept;
  assign accept = byte_valid && !redirect;

  cbd_op_class u_class (.op(byte_data[OP_W-1:0]), .kind(hd_kind));

  cbd_fetch_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_pc(redirect_pc),
    .step(byte_valid), .dpc(dpc), .pc(fetch_pc)
  );

  cbd_simm4 #(.OUT_W(WORD_W)) u_simm4 (.code(ry), .value(simm4));

  always_comb begin
    state_d = state_q;  kind_d = kind_q;
    xc_d = xc_q;  tf_d = tf_q;  em_d = em_q;  drv_d = drv_q;  dr_d = dr_q;
    rx_d = rx_q;  ry_d = ry_q;  op_d = op_q;  cnd_d = cnd_q;  lo_d = lo_q;
    fin = 1'b0;  fin_ill = 1'b0;  fin_immv = 1'b0;  fin_imm = '0;
    fin_rx = rx_q;  fin_ry = ry_q;  fin_op = op_q;  fin_cnd = cnd_q;
    if (byte_valid) begin
      case (state_q)
        ST_HEAD: begin
          fin_op  = byte_data[OP_W-1:0];
          fin_cnd = byte_data[BYTE_W-1:OP_W];
          fin_rx  = '0;
          fin_ry  = '0;
          if (byte_data[BYTE_W-1:OP_W] == COND_PREFIX) begin
            if (xc_q) begin
              fin = 1'b1;  fin_ill = 1'b1;
            end else if (byte_data[RIDX_W]) begin
              drv_d = 1'b1;
              dr_d  = byte_data[RIDX_W-1:0];
            end else begin
              case (byte_data[RIDX_W-1:0])
                4'h0:    xc_d = 1'b1;
                4'h1:    tf_d = ~tf_q;
                4'h2:    em_d = 1'b1;
                default: begin fin = 1'b1; fin_ill = 1'b1; end
              endcase
            end
          end else begin
            op_d   = byte_data[OP_W-1:0];
            cnd_d  = byte_data[BYTE_W-1:OP_W];
            kind_d = hd_kind;
            rx_d   = '0;
            ry_d   = '0;
            case (hd_kind)
              K_RSVD:   begin fin = 1'b1; fin_ill = 1'b1; end
              K_SINGLE: fin = 1'b1;
              K_BARE16: state_d = ST_LO;
              default:  state_d = ST_PAIR;
            endcase
          end
        end
        ST_PAIR: begin
          rx_d   = byte_data[BYTE_W-1:RIDX_W];
          ry_d   = byte_data[RIDX_W-1:0];
          fin_rx = rx_d;
          fin_ry = ry_d;
          if (ry_d == RIDX_IMM && (kind_q == K_PAIR_VY || kind_q == K_PAIR_V8))
            state_d = ST_LO;
          else
            fin = 1'b1;
        end
        ST_LO: begin
          if (kind_q == K_PAIR_V8) begin
            fin = 1'b1;  fin_immv = 1'b1;
            fin_imm = {{(WORD_W-BYTE_W){1'b0}}, byte_data};
          end else begin
            lo_d    = byte_data;
            state_d = ST_HI;
          end
        end
        default: begin
          fin = 1'b1;  fin_immv = 1'b1;
          fin_imm = {byte_data, lo_q};
        end
      endcase
    end
    if (fin || redirect) begin
      state_d = ST_HEAD;
      xc_d = 1'b0;  tf_d = 1'b0;  em_d = 1'b0;  drv_d = 1'b0;
    end
    if (redirect) fin = 1'b0;
  end

  assign fin_cond4 = {xc_q, fin_cnd};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HEAD;  kind_q <= K_SINGLE;
      xc_q <= 1'b0;  tf_q <= 1'b0;  em_q <= 1'b0;  drv_q <= 1'b0;
      dr_q <= '0;  rx_q <= '0;  ry_q <= '0;  op_q <= '0;  cnd_q <= '0;  lo_q <= '0;
      done <= 1'b0;  illegal <= 1'b0;  cond <= '0;  opcode <= '0;
      rx <= '0;  ry <= '0;  rd <= '0;  rdx <= 4'h1;
      has_imm <= 1'b0;  imm <= '0;
      pfx_tf <= 1'b0;  pfx_em <= 1'b0;  pfx_dr <= 1'b0;  upd_flags <= 1'b0;
    end else begin
      state_q <= state_d;  kind_q <= kind_d;
      xc_q <= xc_d;  tf_q <= tf_d;  em_q <= em_d;  drv_q <= drv_d;
      dr_q <= dr_d;  rx_q <= rx_d;  ry_q <= ry_d;  op_q <= op_d;  cnd_q <= cnd_d;  lo_q <= lo_d;
      done <= fin;
      if (fin) begin
        illegal   <= fin_ill;
        cond      <= fin_cond4;
        opcode    <= fin_op;
        rx        <= fin_rx;
        ry        <= fin_ry;
        rd        <= drv_q ? dr_q : fin_rx;
        rdx       <= (drv_q ? dr_q : fin_rx) ^ 4'h1;
        has_imm   <= fin_immv;
        imm       <= fin_imm;
        pfx_tf    <= tf_q;
        pfx_em    <= em_q;
        pfx_dr    <= drv_q;
        upd_flags <= (fin_cond4 == COND_ALWAYS) ^ tf_q;
      end
    end
  end

  a_r10_simm4_nonzero: assert property (@(posedge clk) disable iff (rst)
    simm4 != '0);
  a_r3_rd_defaults_rx: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && !pfx_dr) |-> rd == rx);
  a_r12_no_done_after_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !done);
  a_r14_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || ($stable(opcode) && $stable(rd) && $stable(imm) && $stable(cond))));
  a_r13_plain_always_writes: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && cond == COND_ALWAYS && !pfx_tf) |-> upd_flags);
  a_r6_imm_after_pair: assert property (@(posedge clk) disable iff (rst)
    (done && has_imm && !accept && state_q == ST_HEAD) |-> (ry == RIDX_IMM || ry == '0));
endmodule

// File: tb/code_byte_decoder_bench.sv
module code_byte_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect = 1'b0;
  logic [15:0] redirect_pc = '0;
  logic [15:0] dpc = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [15:0] fetch_pc, imm, simm4;
  logic        done, illegal, has_imm, pfx_tf, pfx_em, pfx_dr, upd_flags;
  logic [3:0]  cond, rx, ry, rd, rdx;
  logic [4:0]  opcode;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  code_byte_decoder u_code_byte_decoder (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_pc(redirect_pc),
    .dpc(dpc), .byte_valid(byte_valid), .byte_data(byte_data),
    .fetch_pc(fetch_pc), .done(done), .illegal(illegal), .cond(cond),
    .opcode(opcode), .rx(rx), .ry(ry), .rd(rd), .rdx(rdx),
    .has_imm(has_imm), .imm(imm), .simm4(simm4), .pfx_tf(pfx_tf),
    .pfx_em(pfx_em), .pfx_dr(pfx_dr), .upd_flags(upd_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; the byte is captured at the next posedge
  task automatic put(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic jump(input logic [15:0] a);
    redirect = 1'b1;  redirect_pc = a;
    @(negedge clk);
    redirect = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset pc", fetch_pc, 16'h0000);
    chk("R14 reset done", done, 0);
  endtask

  task automatic t_reg_pair;
    put(8'hE0);
    chk("R14 no done mid", done, 0);
    put(8'h35);
    chk("R14 done", done, 1);
    chk("R1 opcode", opcode, 5'h00);
    chk("R1 cond", cond, 4'h7);
    chk("R5 rx", rx, 4'h3);
    chk("R5 ry", ry, 4'h5);
    chk("R3 rd=rx", rd, 4'h3);
    chk("R3 rdx", rdx, 4'h2);
    chk("R7 no imm", has_imm, 0);
    chk("R13 always writes", upd_flags, 1);
    @(negedge clk);
    chk("R14 one-cycle", done, 0);
    chk("R14 hold", rx, 4'h3);
  endtask

  task automatic t_imm16;
    put(8'hEC); put(8'h4F); put(8'h34);
    chk("R6 no done before high", done, 0);
    put(8'h12);
    chk("R6 done", done, 1);
    chk("R6 has_imm", has_imm, 1);
    chk("R6 imm little-endian", imm, 16'h1234);
    chk("R6 rx", rx, 4'h4);
  endtask

  task automatic t_imm8;
    put(8'hF3); put(8'h2F);
    chk("R7 wait byte imm", done, 0);
    put(8'hAB);
    chk("R7 done", done, 1);
    chk("R7 imm zext", imm, 16'h00AB);
    put(8'hF9); put(8'h34);
    chk("R7 port form no imm done", done, 1);
    chk("R7 port form has_imm", has_imm, 0);
  endtask

  task automatic t_prefixes;
    put(8'hD9); put(8'hC1); put(8'hC2); put(8'hC0); put(8'h01);
    chk("R2 no done on prefixes", done, 0);
    put(8'h12);
    chk("R2 done", done, 1);
    chk("R2 extended cond", cond, 4'h8);
    chk("R3 rd from prefix", rd, 4'h9);
    chk("R3 rdx pair", rdx, 4'h8);
    chk("R3 pfx_dr", pfx_dr, 1);
    chk("R2 pfx_tf", pfx_tf, 1);
    chk("R2 pfx_em", pfx_em, 1);
    chk("R13 conditional toggled", upd_flags, 1);
    chk("R1 opcode", opcode, 5'h01);
    put(8'hC1); put(8'hC1); put(8'hFF);
    chk("R2 double toggle", pfx_tf, 0);
    chk("R13 double toggle writes", upd_flags, 1);
  endtask

  task automatic t_illegal;
    put(8'hC0); put(8'hC1);
    chk("R4 prefix after extend", {done, illegal}, 2'b11);
    put(8'hC5);
    chk("R4 reserved prefix", {done, illegal}, 2'b11);
    put(8'hEE);
    chk("R4 reserved opcode", {done, illegal}, 2'b11);
    put(8'hEF);
    chk("R4 reserved opcode 0F", {done, illegal}, 2'b11);
    put(8'hFE);
    chk("R9 legal clears illegal", {done, illegal}, 2'b10);
  endtask

  task automatic t_bare_single;
    put(8'hF5); put(8'h00);
    chk("R8 wait high", done, 0);
    put(8'h80);
    chk("R8 done", done, 1);
    chk("R8 imm", imm, 16'h8000);
    chk("R8 rx ry zero", {rx, ry}, 8'h00);
    put(8'h1F);
    chk("R9 nop single", {done, opcode}, {1'b1, 5'h1F});
    chk("R13 conditional no write", upd_flags, 0);
    put(8'hFD);
    chk("R9 back-to-back", {done, opcode}, {1'b1, 5'h1D});
  endtask

  task automatic t_simm4;
    put(8'hFC); put(8'h6F);
    chk("R10 -1", simm4, 16'hFFFF);
    chk("R10 no imm", has_imm, 0);
    put(8'hFC); put(8'h60);
    chk("R10 +1", simm4, 16'h0001);
    put(8'hFC); put(8'h67);
    chk("R10 +8", simm4, 16'h0008);
    put(8'hFC); put(8'h68);
    chk("R10 -8", simm4, 16'hFFF8);
  endtask

  task automatic t_fetch;
    dpc = 16'd2;
    jump(16'h2000);
    chk("R11 redirect", fetch_pc, 16'h2000);
    put(8'hFE); put(8'hFE);
    chk("R11 stride", fetch_pc, 16'h2006);
    @(negedge clk);
    chk("R11 hold", fetch_pc, 16'h2006);
    dpc = 16'd0;
  endtask

  task automatic t_collide;
    jump(16'h3000);
    put(8'hE0);
    redirect = 1'b1;  redirect_pc = 16'h4000;
    byte_valid = 1'b1;  byte_data = 8'h35;
    @(negedge clk);
    redirect = 1'b0;  byte_valid = 1'b0;
    chk("R12 pc takes target", fetch_pc, 16'h4000);
    chk("R12 no done", done, 0);
    put(8'hFE);
    chk("R12 fresh decode", {done, opcode}, {1'b1, 5'h1E});
    chk("R12 pc after", fetch_pc, 16'h4001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_pair();
    t_imm16();
    t_imm8();
    t_prefixes();
    t_illegal();
    t_bare_single();
    t_simm4();
    t_fetch();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule